// File: doc/BRIEF.md
# Phased Dual-Access Data RAM

This block is a 16-bit-wide on-chip data RAM that completes one write and one read within a single processor cycle. Each processor cycle spans two periods of the block clock and is split into two halves. The first half is the write half and the second half is the read half. A store is committed at the clock edge that closes the write half. A load is then taken from the array at the edge that closes the read half. A store and a load that meet in the same cycle therefore both finish, and a load from the address just stored returns the new word without a stall.

The requester drives both request ports at the start of a processor cycle and holds them through both halves. The `phase` output tells the requester which half is current. The read result is registered and held until the next read. The `ready` output is always high, because this RAM never asks the requester to wait. Addresses at or beyond the array depth (default 544 words on a 10-bit address) never touch storage.

Top module: `dual_phase_ram`

## Requirements
- R1: After reset `phase` is 0 (write half). It inverts on every clock edge, so a processor cycle is one clock with `phase`=0 followed by one clock with `phase`=1.
- R2: When `wr_en` is 1 and `wr_addr` < DEPTH at the clock edge that ends a write half (`phase`=0), `wr_data` is stored at `wr_addr`.
- R3: When `rd_en` is 1 at the clock edge that ends a read half (`phase`=1), `rd_data` takes the word stored at `rd_addr` at that edge and shows it from then on.
- R4: When a write and a read to the same in-range address are requested in one processor cycle, `rd_data` at the end of that cycle equals the new `wr_data`, with no extra cycle.
- R5: A read with `wr_en` at 0 completes in the same processor cycle and returns the previously stored word.
- R6: `rd_data` keeps its value through any processor cycle whose `rd_en` is 0.
- R7: A write whose address is at or above DEPTH changes no stored word. In particular, it does not alias onto the address with the top bit dropped.
- R8: A read whose address is at or above DEPTH returns 0.
- R9: `ready` is 1 in every cycle, including the cycles with simultaneous write and read.
- R10: Synchronous active-low reset clears `rd_data` to 0 and `phase` to 0. Reset does not clear the storage array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, two periods per processor cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request, held for the whole processor cycle |
| wr_addr | input | 10 | Write word address |
| wr_data | input | 16 | Write word |
| rd_en | input | 1 | Read request, held for the whole processor cycle |
| rd_addr | input | 10 | Read word address |
| rd_data | output | 16 | Registered read result, held between reads |
| phase | output | 1 | 0 during the write half, 1 during the read half |
| ready | output | 1 | Constant ready indication, never low |

## Verification
The two functions that can fall in the same processor cycle are the store and the load. The write-then-read order within the cycle decides whether a load sees the old word or the new one. The bench provokes this meeting both on purpose, by issuing a write and a read to one address in the same cycle (including the first and last word), and at random, by drawing read addresses from a small window around recent writes. Each result is compared with a bench model that applies the write before the read, so any reordering of the halves or any extra delay shows up as a stale word.

// File: rtl/dpr_pkg.sv
// Package: shared widths and types for the phased dual-access RAM.
// Assumes one processor cycle equals two block clock periods.
package dpr_pkg;
    localparam int DATA_W_DEF = 16;
    localparam int ADDR_W_DEF = 10;
    localparam int DEPTH_DEF  = 544;

    // Half-cycle names: write half first, read half second.
    typedef enum logic {
        HALF_WRITE = 1'b0,
        HALF_READ  = 1'b1
    } half_t;
endpackage

// File: rtl/dpr_phase_gen.sv
// Module: dpr_phase_gen
// Produces the half-cycle indication. It alternates write half and read half
// on every clock edge. Assumes the block clock runs at twice the processor
// cycle rate and that reset is released on a processor-cycle boundary.
module dpr_phase_gen
    import dpr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output half_t half
);
    half_t half_q;

    // Toggle the half on every edge, and start in the write half after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= HALF_WRITE;
        end else begin
            half_q <= (half_q == HALF_WRITE) ? HALF_READ : HALF_WRITE;
        end
    end

    assign half = half_q;
endmodule

// File: rtl/dpr_store.sv
// Module: dpr_store
// The storage array. It commits a write at the edge that closes the write
// half, and it offers the word at the read address combinationally. Addresses
// at or beyond DEPTH neither write nor read (the read gives zero). The array
// is not reset. Assumes request inputs are held for a full processor cycle.
module dpr_store
    import dpr_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DEPTH  = DEPTH_DEF
) (
    input  logic              clk,
    input  half_t             half,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam logic [ADDR_W:0] LIMIT = DEPTH[ADDR_W:0];

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_in_range;
    logic              rd_in_range;
    logic              wr_fire;

    // Decode whether each address falls inside the array.
    always_comb begin
        wr_in_range = ({1'b0, wr_addr} < LIMIT);
        rd_in_range = ({1'b0, rd_addr} < LIMIT);
        wr_fire     = wr_en && wr_in_range && (half == HALF_WRITE);
    end

    // Commit the write at the close of the write half.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the addressed word, or zero outside the array.
    always_comb begin
        rd_word = rd_in_range ? mem[rd_addr] : '0;
    end
endmodule

// File: rtl/dpr_read_stage.sv
// Module: dpr_read_stage
// Output register. It captures the array word at the edge that closes the
// read half when a read is requested, and holds it otherwise. Because the
// write was committed one edge earlier, a same-address read sees the new word.
module dpr_read_stage
    import dpr_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  half_t             half,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] data_q;

    // Register the read result at the close of the read half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_en && (half == HALF_READ)) begin
            data_q <= rd_word;
        end
    end

    assign rd_data = data_q;
endmodule

// File: rtl/dual_phase_ram.sv
// Module: dual_phase_ram (top)
// Dual-access data RAM. Each processor cycle is two clocks: the write half
// (phase 0) and then the read half (phase 1). Both requests are accepted in
// one cycle and the requester is never stalled. Assumes the requests are
// presented at the start of the write half and held through the read half.
module dual_phase_ram
    import dpr_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DEPTH  = DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              phase,
    output logic              ready
);
    half_t             half;
    logic [DATA_W-1:0] rd_word;

    dpr_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .half  (half)
    );

    dpr_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .half    (half),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    dpr_read_stage #(
        .DATA_W (DATA_W)
    ) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .half    (half),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .rd_data (rd_data)
    );

    // Expose the half and the permanent ready.
    assign phase = (half == HALF_READ);
    assign ready = 1'b1;
endmodule

// File: rtl/dpr_checker.sv
// Module: dpr_checker
// Port-level properties of dual_phase_ram, attached with bind below.
module dpr_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 544
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              phase,
    input logic              ready
);
    localparam logic [ADDR_W:0] LIMIT = DEPTH[ADDR_W:0];

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!phase && rd_data == '0));

    // R1
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase != $past(phase)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase && rd_en) |=> $stable(rd_data));

    // R4
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!phase && wr_en) && phase && rd_en
         && rd_addr == $past(wr_addr) && ({1'b0, rd_addr} < LIMIT))
        |=> (rd_data == $past(wr_data, 2)));

    // R8
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && rd_en && !({1'b0, rd_addr} < LIMIT)) |=> (rd_data == '0));

    // R9
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |-> ready);
endmodule

bind dual_phase_ram dpr_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_dpr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .phase   (phase),
    .ready   (ready)
);

// File: tb/dual_phase_ram_test.sv
// Bench for dual_phase_ram: directed corners plus seeded random traffic.
module dual_phase_ram_test;
    localparam int DW = 16;
    localparam int AW = 10;
    localparam int DEPTH = 544;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          phase;
    logic          ready;

    int checks = 0;
    int fails = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] last_rd = '0;

    always #2 clk = ~clk;

    dual_phase_ram uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .phase(phase), .ready(ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected read result: write half applied before read half.
    function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] ra);
        if (ra >= DEPTH) return '0;
        return model[ra];
    endfunction

    // One processor cycle; called at a negedge with phase 0.
    task automatic cycle(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                         input logic re, input logic [AW-1:0] ra, input string req);
        logic [DW-1:0] exp;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        @(negedge clk);
        check("R1 read half", {31'd0, phase}, 32'd1);
        check("R9 ready", {31'd0, ready}, 32'd1);
        @(negedge clk);
        check("R1 write half", {31'd0, phase}, 32'd0);
        if (we && wa < DEPTH) model[wa] = wd;
        exp = re ? expect_read(ra) : last_rd;
        check(re ? req : "R6 hold", {16'd0, rd_data}, {16'd0, exp});
        last_rd = exp;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        int unused_seed;
        #200000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 rd_data", {16'd0, rd_data}, 32'd0);
        check("R10 phase", {31'd0, phase}, 32'd0);
        rst_n = 1'b1;
        // R2: fill the array
        for (int i = 0; i < DEPTH; i++) cycle(1'b1, AW'(i), DW'(i * 37 + 5), 1'b0, '0, "R2");
        // R3/R5: read back without writes
        cycle(1'b0, '0, '0, 1'b1, AW'(10), "R5 read no write");
        cycle(1'b0, '0, '0, 1'b1, AW'(DEPTH - 1), "R3 last word");
        // R4: same-cycle store and load, first and last word
        cycle(1'b1, AW'(0), 16'hBEEF, 1'b1, AW'(0), "R4 same addr first");
        cycle(1'b1, AW'(DEPTH - 1), 16'h1234, 1'b1, AW'(DEPTH - 1), "R4 same addr last");
        cycle(1'b1, AW'(5), 16'hAAAA, 1'b1, AW'(6), "R3 different addr");
        // R6: hold
        cycle(1'b1, AW'(6), 16'h5555, 1'b0, '0, "R6");
        // R7: out-of-range write must not alias onto a - 512
        cycle(1'b1, AW'(600), 16'hDEAD, 1'b1, AW'(600 - 512), "R7 no alias");
        cycle(1'b1, AW'(1023), 16'hF00D, 1'b1, AW'(1023 - 512), "R7 no alias top");
        // R8: out-of-range read
        cycle(1'b0, '0, '0, 1'b1, AW'(DEPTH), "R8 oor read");
        cycle(1'b1, AW'(700), 16'h7777, 1'b1, AW'(700), "R8 oor same addr");
        // Random mix, read addresses near the write address
        for (int n = 0; n < 3000; n++) begin
            a = AW'($urandom_range(0, DEPTH + 40));
            d = DW'($urandom);
            cycle($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 3) != 0,
                  ($urandom_range(0, 1) == 1) ? a : AW'(a + AW'($urandom_range(0, 3))),
                  "R4 random");
        end
        // R10: reset again clears output
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R10 rd_data re-reset", {16'd0, rd_data}, 32'd0);
        check("R10 phase re-reset", {31'd0, phase}, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule